// File: doc/BRIEF.md
# DMA Request Source Selector

This block produces the transfer request for one DMA channel. A 4-bit select field picks one of the raw hardware request lines. Each line passes through a two-stage synchronizer, and then an edge detector looks for the active edge of the chosen line. That edge uses the fixed polarity of the line. A qualifying edge sets a capture flag, and a software trigger can set the same flag. The flag stays set until the channel engine acknowledges it. A channel enable gates the flag onto the request output.

A single 8-bit control write port programs the block. One group of lines (codes 5 to 13) can request only while a separate gate bit is set. A self-clearing clear bit empties the capture flag. Software sets this clear bit in the same write that sets the enable, so that no stale request fires at turn-on. The engine consumes `dreq_o` and answers with `dack_i`.

Top module: `dma_req_select`

## Requirements
- R1: After reset, `dreq_o` is 0 and `ctl_rdata` reads 0x00.
- R2: Control byte layout on write is: bits [3:0] source select, bit 4 software trigger, bit 5 gate, bit 6 capture clear, bit 7 channel enable. `ctl_rdata` returns {enable, 0, gate, 0, select}, so the trigger and clear bits always read 0.
- R3: For codes 1-4 and 8-15, a 0-to-1 transition on the selected line sets the capture. With the channel enabled, `dreq_o` rises on the third rising clock edge after the line changes.
- R4: Codes 5, 6 and 7 capture on a 1-to-0 transition of the selected line, with the same latency. A 0-to-1 transition on these lines has no effect.
- R5: With select code 0, no line activity ever sets the capture.
- R6: Codes 5 to 13 capture only while the gate bit is 1. Codes outside that range ignore the gate bit.
- R7: A write with the trigger bit set sets the capture at that clock edge.
- R8: A write with the clear bit set empties the capture. If a trigger or a line edge occurs in the same cycle, the capture ends set.
- R9: `dreq_o` is the capture gated by the enable bit. A capture made while disabled is kept, and appears once the enable is set without a clear.
- R10: The capture holds until `dack_i` is high at a clock edge. An acknowledge in the same cycle as a new set event leaves it set.
- R11: Changing the select code produces no capture by itself, even when the new line's level differs from the old one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_raw | input | 16 | Raw asynchronous request lines, index equals select code |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 8 | Control write byte |
| ctl_rdata | output | 8 | Control readback |
| dreq_o | output | 1 | Transfer request to the channel engine |
| dack_i | input | 1 | Acknowledge from the channel engine |

## Verification
The bench switches the select code between lines that sit at different levels. A design that keeps the old line's history would report a phantom edge here. It also raises the active edge on a gated line with the gate bit off, and on an ungated line; a misplaced gate range or an inverted polarity shows up as a capture that is missing or extra. Acknowledge and trigger are driven in the same cycle, and clear and trigger are written together. A design with the wrong priority would drop a request or keep a stale one. The clear is also written with the enable after a capture made while disabled, which exposes a request that fires at turn-on.

// File: rtl/dma_rqsel_pkg.sv
package dma_rqsel_pkg;
    localparam int NUM_SRC   = 16;
    localparam int SEL_W     = 4;
    localparam int SYNC_LEN  = 2;
    localparam logic [NUM_SRC-1:0] FALL_MASK = 16'h00E0;
    localparam int GATE_LO   = 5;
    localparam int GATE_HI   = 13;

    localparam int B_TRIG = 4;
    localparam int B_GATE = 5;
    localparam int B_CLR  = 6;
    localparam int B_EN   = 7;

    typedef struct packed {
        logic             en;
        logic             gate;
        logic [SEL_W-1:0] sel;
    } ctl_t;

    typedef struct packed {
        ctl_t ctl;
        logic cap;
    } top_st_t;
endpackage

// File: rtl/dma_rqsel_sync.sv
module dma_rqsel_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/dma_rqsel_edge.sv
module dma_rqsel_edge #(
    parameter int           N         = 16,
    parameter int           SEL_W     = 4,
    parameter logic [N-1:0] FALL_MASK = '0,
    parameter int           GATE_LO   = 5,
    parameter int           GATE_HI   = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     line_i,
    input  logic [SEL_W-1:0] sel_cur_i,
    input  logic [SEL_W-1:0] sel_nxt_i,
    input  logic             gate_en_i,
    output logic             edge_o
);
    logic hist_d, hist_q;
    logic lvl, in_gated, allowed;

    function automatic logic active_level(input logic [N-1:0] v, input logic [SEL_W-1:0] s);
        return v[s] ^ FALL_MASK[s];
    endfunction

    always_comb begin
        // history always tracks the line that will be selected next cycle
        hist_d   = active_level(line_i, sel_nxt_i);
        lvl      = active_level(line_i, sel_cur_i);
        in_gated = (sel_cur_i >= SEL_W'(GATE_LO)) && (sel_cur_i <= SEL_W'(GATE_HI));
        allowed  = (sel_cur_i != '0) && (!in_gated || gate_en_i);
        edge_o   = allowed && lvl && !hist_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= 1'b0;
        else        hist_q <= hist_d;
    end
endmodule

// File: rtl/dma_req_select.sv
module dma_req_select
    import dma_rqsel_pkg::*;
#(
    parameter int N       = NUM_SRC,
    parameter int SYNC_N  = SYNC_LEN,
    parameter int CTL_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     src_raw,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_rdata,
    output logic             dreq_o,
    input  logic             dack_i
);
    localparam int SW = $clog2(N);

    top_st_t     st_d, st_q;
    logic [N-1:0] line_sync;
    logic         hw_edge;
    logic         sw_trig, cap_clr, set_evt;

    dma_rqsel_sync #(.W(N), .STAGES(SYNC_N)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (src_raw),
        .sync_o  (line_sync)
    );

    dma_rqsel_edge #(
        .N(N), .SEL_W(SW), .FALL_MASK(FALL_MASK),
        .GATE_LO(GATE_LO), .GATE_HI(GATE_HI)
    ) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_i    (line_sync),
        .sel_cur_i (st_q.ctl.sel),
        .sel_nxt_i (st_d.ctl.sel),
        .gate_en_i (st_q.ctl.gate),
        .edge_o    (hw_edge)
    );

    always_comb begin
        st_d    = st_q;
        sw_trig = ctl_we && ctl_wdata[B_TRIG];
        cap_clr = ctl_we && ctl_wdata[B_CLR];
        set_evt = hw_edge || sw_trig;
        if (ctl_we) begin
            st_d.ctl.sel  = ctl_wdata[SW-1:0];
            st_d.ctl.gate = ctl_wdata[B_GATE];
            st_d.ctl.en   = ctl_wdata[B_EN];
        end
        st_d.cap = (st_q.cap && !dack_i && !cap_clr) || set_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        ctl_rdata            = '0;
        ctl_rdata[SW-1:0]    = st_q.ctl.sel;
        ctl_rdata[B_GATE]    = st_q.ctl.gate;
        ctl_rdata[B_EN]      = st_q.ctl.en;
    end

    assign dreq_o = st_q.cap && st_q.ctl.en;
endmodule

// File: rtl/dma_req_select_chk.sv
module dma_req_select_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_we,
    input logic [7:0] ctl_wdata,
    input logic [7:0] ctl_rdata,
    input logic       dreq_o,
    input logic       dack_i,
    input logic       hw_edge
);
    AST_SEL_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata[3:0] == 4'd0) |-> !hw_edge); // R5
    AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata[3:0] >= 4'd5 && ctl_rdata[3:0] <= 4'd13 && !ctl_rdata[5]) |-> !hw_edge); // R6
    AST_TRIG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_wdata[4] && ctl_wdata[7]) |=> dreq_o); // R7
    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_wdata[6] && !ctl_wdata[4] && !hw_edge) |=> !dreq_o); // R8
    AST_HOLD_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (dreq_o && !dack_i && !(ctl_we && (ctl_wdata[6] || !ctl_wdata[7]))) |=> dreq_o); // R10
    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (dreq_o && dack_i && !hw_edge && !(ctl_we && (ctl_wdata[4] || ctl_wdata[7]))) |=> !dreq_o); // R10
endmodule

bind dma_req_select dma_req_select_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .ctl_rdata (ctl_rdata),
    .dreq_o    (dreq_o),
    .dack_i    (dack_i),
    .hw_edge   (hw_edge)
);

// File: tb/tb_dma_req_select.sv
module tb_dma_req_select;
    localparam int HALF = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src_raw = '0;
    logic        ctl_we = 1'b0;
    logic [7:0]  ctl_wdata = '0;
    logic [7:0]  ctl_rdata;
    logic        dreq_o;
    logic        dack_i = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    string tag = "R1";
    bit done = 1'b0;

    always #HALF clk = ~clk;

    dma_req_select dut (
        .clk(clk), .rst_n(rst_n), .src_raw(src_raw), .ctl_we(ctl_we),
        .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .dreq_o(dreq_o), .dack_i(dack_i)
    );

    // behavioural reference
    logic [15:0] delay_q[$];
    logic [15:0] prev_seen;
    bit          m_cap, m_en, m_gate;
    logic [3:0]  m_sel;

    function automatic bit act(input logic [15:0] v, input logic [3:0] s);
        bit falling = (s == 4'd5) || (s == 4'd6) || (s == 4'd7);
        return falling ? !v[s] : v[s];
    endfunction

    initial begin
        delay_q = '{16'h0, 16'h0};
        prev_seen = '0;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            delay_q = '{16'h0, 16'h0};
            prev_seen = '0; m_cap = 0; m_en = 0; m_gate = 0; m_sel = '0;
        end else begin
            logic [15:0] seen;
            bit gated, hw, set_e, clr_e;
            seen  = delay_q[0];
            gated = (m_sel >= 5) && (m_sel <= 13);
            hw    = (m_sel != 0) && (!gated || m_gate) && act(seen, m_sel) && !act(prev_seen, m_sel);
            set_e = hw || (ctl_we && ctl_wdata[4]);
            clr_e = ctl_we && ctl_wdata[6];
            m_cap = (m_cap && !dack_i && !clr_e) || set_e;
            if (ctl_we) begin
                m_sel = ctl_wdata[3:0]; m_gate = ctl_wdata[5]; m_en = ctl_wdata[7];
            end
            prev_seen = seen;
            delay_q.push_back(src_raw);
            void'(delay_q.pop_front());
        end
        #5;
        if (!done) begin
            n_cmp++;
            if (dreq_o !== (m_cap && m_en) || ctl_rdata !== {m_en, 1'b0, m_gate, 1'b0, m_sel}) begin
                n_bad++;
                $display("FAIL %s: dreq=%0b rdata=%02h expected dreq=%0b rdata=%02h", tag,
                         dreq_o, ctl_rdata, m_cap && m_en, {m_en, 1'b0, m_gate, 1'b0, m_sel});
            end
        end
    end

    task automatic chk(input bit act_v, input bit exp_v, input string t);
        n_cmp++;
        if (act_v !== exp_v) begin
            n_bad++;
            $display("FAIL %s: dreq=%0b expected %0b", t, act_v, exp_v);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = d;
        @(negedge clk); ctl_we = 1'b0; ctl_wdata = '0;
    endtask

    task automatic ack1();
        @(negedge clk); dack_i = 1'b1;
        @(negedge clk); dack_i = 1'b0;
    endtask

    task automatic line(input int i, input bit v);
        @(negedge clk); src_raw[i] = v;
    endtask

    initial begin
        #(HALF * 2 * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        chk(dreq_o, 1'b0, "R1");
        n_cmp++; if (ctl_rdata !== 8'h00) begin n_bad++; $display("FAIL R1: rdata=%02h expected 00", ctl_rdata); end

        tag = "R3"; // rising source 1, enable+clear, select 1
        wr(8'hC1);
        n_cmp++; if (ctl_rdata !== 8'h81) begin n_bad++; $display("FAIL R2: rdata=%02h expected 81", ctl_rdata); end
        line(1, 1'b1);
        cyc(2); chk(dreq_o, 1'b0, "R3");
        cyc(1); chk(dreq_o, 1'b1, "R3");
        tag = "R10"; cyc(4); chk(dreq_o, 1'b1, "R10");
        ack1(); chk(dreq_o, 1'b0, "R10");
        line(1, 1'b0); cyc(4); chk(dreq_o, 1'b0, "R3");

        tag = "R5"; wr(8'hA0);
        for (int k = 0; k < 16; k++) begin line(k, 1'b1); end
        cyc(4);
        src_raw = '0; cyc(4); chk(dreq_o, 1'b0, "R5");

        tag = "R4"; line(6, 1'b1); wr(8'hA6); cyc(3); chk(dreq_o, 1'b0, "R4");
        line(6, 1'b0); cyc(3); chk(dreq_o, 1'b1, "R4");
        ack1(); line(6, 1'b1); cyc(4); chk(dreq_o, 1'b0, "R4");

        tag = "R6"; wr(8'h86); line(6, 1'b0); cyc(4); chk(dreq_o, 1'b0, "R6");
        wr(8'h8E); line(14, 1'b1); cyc(3); chk(dreq_o, 1'b1, "R6");
        ack1(); line(14, 1'b0); cyc(3);

        tag = "R11"; line(3, 1'b1); line(9, 1'b0); line(5, 1'b0);
        wr(8'hA9); cyc(3); wr(8'hA3); cyc(4); chk(dreq_o, 1'b0, "R11");
        wr(8'hA5); cyc(4); chk(dreq_o, 1'b0, "R11");
        wr(8'hA9); cyc(4); chk(dreq_o, 1'b0, "R11");
        src_raw = '0; cyc(4);

        tag = "R7"; wr(8'h90); chk(dreq_o, 1'b1, "R7");
        n_cmp++; if (ctl_rdata !== 8'h80) begin n_bad++; $display("FAIL R2: rdata=%02h expected 80", ctl_rdata); end
        tag = "R10"; @(negedge clk); dack_i = 1'b1; ctl_we = 1'b1; ctl_wdata = 8'h90;
        @(negedge clk); dack_i = 1'b0; ctl_we = 1'b0; ctl_wdata = '0;
        chk(dreq_o, 1'b1, "R10");
        tag = "R8"; wr(8'hC0); chk(dreq_o, 1'b0, "R8");
        wr(8'hD0); chk(dreq_o, 1'b1, "R8");
        n_cmp++; if (ctl_rdata !== 8'h80) begin n_bad++; $display("FAIL R2: rdata=%02h expected 80", ctl_rdata); end
        wr(8'hC0);

        tag = "R9"; wr(8'h10); cyc(2); chk(dreq_o, 1'b0, "R9");
        wr(8'hC0); chk(dreq_o, 1'b0, "R9");
        wr(8'h10); wr(8'h80); chk(dreq_o, 1'b1, "R9");
        wr(8'h00); chk(dreq_o, 1'b0, "R9");
        cyc(3);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule